// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block is a real-time clock peripheral reached over a simple 32-bit register bus. The bus has a select, a write enable, a 12-bit byte offset, write data and read data. A 32-bit seconds counter advances once for each pulse on a one-second tick input. Software can load the counter with a start value, which is also kept for read-back. It can program a match value that raises an alarm. It controls that alarm through a mask bit, a raw status bit, a masked status view and a write-to-clear register.

The alarm compares the wrapping 32-bit count with the match value. A match value below the current count is therefore reached after the counter rolls over. A single level interrupt output carries the raw status ANDed with the mask. The clock cannot be switched off, and the control register always reports it as enabled. The top 32 bytes of the 4 KB window hold eight fixed identification bytes, one per word.

Accesses with no defined meaning change no state. They return zero and produce a one-cycle error pulse.

Top module: `sec_rtc`

## Requirements
- R1: While reset is asserted and immediately after it, the counter, load, match, mask and raw status are zero, and irq_o, err_o and rdata_o are low.
- R2: Each cycle with tick_i high and no load write increments the count by one, wrapping from 0xFFFFFFFF to 0. Without a tick or a load write the count holds. Reading byte offset 0x00 returns the live count.
- R3: A write to offset 0x08 sets the count to the written value, and a later read of 0x08 returns that value. A load write wins over a tick in the same cycle.
- R4: A write to offset 0x04 sets the match value. On a tick where the incremented count equals the match value, the raw status (offset 0x14, bit 0) is set, including when the match is reached through wraparound.
- R5: irq_o equals raw status AND mask bit (offset 0x10, bit 0 holds write data bit 0). A read of offset 0x18 returns that same AND in bit 0.
- R6: Any write to offset 0x1C clears the raw status, whatever the data. If the alarm sets the raw status in the same cycle, the status ends up set.
- R7: A read of offset 0x0C always returns 0x00000001. A write there is accepted and has no effect.
- R8: Reads of word offsets 0xFE0 through 0xFFC return, in address order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0.
- R9: A read of 0x1C, a misaligned offset or an undefined offset, and a write to 0x00, 0x14, 0x18, the ID area or an undefined offset, each return zero read data and raise err_o for one cycle. None of them changes the count, load, match, mask or raw status.
- R10: Read data and err_o are registered. They are valid in the cycle after the clock edge that samples the access, and rdata_o is zero when no read was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick, one cycle wide |
| sel_i | input | 1 | Access select |
| wr_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 12 | Byte offset in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse for an access with no defined result |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
The bench drives every input on a falling edge. Each access or tick takes effect at the next rising edge, and the results are sampled at the falling edge after it. Count, status and irq_o are therefore checked one rising edge after the tick or write that changes them. Read data and err_o are checked one rising edge after the read. A same-edge tick plus clear-write and a same-edge tick plus load-write cover the ordering rules. Full sweeps over all 1024 word offsets compare reads and illegal writes against a model computed in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned RTC_AW = 12;
  localparam int unsigned RTC_DW = 32;

  // byte offsets of the defined registers
  localparam int unsigned OFF_CNT   = 'h00;
  localparam int unsigned OFF_MATCH = 'h04;
  localparam int unsigned OFF_LOAD  = 'h08;
  localparam int unsigned OFF_CTRL  = 'h0C;
  localparam int unsigned OFF_MASK  = 'h10;
  localparam int unsigned OFF_RAW   = 'h14;
  localparam int unsigned OFF_MIS   = 'h18;
  localparam int unsigned OFF_CLR   = 'h1C;
  localparam int unsigned ID_WORDS  = 8;

  typedef struct packed {
    logic match_we;
    logic load_we;
    logic mask_we;
    logic clr_we;
  } rtc_wr_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h31;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h14;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned DW = rtc_pkg::RTC_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_we_i,
  input  logic          match_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] lr_o,
  output logic [DW-1:0] mr_o,
  output logic          hit_o
);
  logic [DW-1:0] cnt_q, lr_q, mr_q, cnt_nxt;

  assign cnt_nxt = cnt_q + DW'(1);
  // alarm fires on the increment that lands on the match value
  assign hit_o   = tick_i && !load_we_i && (cnt_nxt == mr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lr_q  <= '0;
      mr_q  <= '0;
    end else begin
      if (load_we_i) begin
        cnt_q <= wdata_i;
        lr_q  <= wdata_i;
      end else if (tick_i) begin
        cnt_q <= cnt_nxt;
      end
      if (match_we_i) mr_q <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;
  assign lr_o  = lr_q;
  assign mr_o  = mr_q;
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_we_i,
  input  logic mask_we_i,
  input  logic mask_d_i,
  output logic raw_o,
  output logic mask_o,
  output logic irq_o
);
  logic raw_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      // set has priority over a same-cycle clear
      if (hit_i)         raw_q <= 1'b1;
      else if (clr_we_i) raw_q <= 1'b0;
      if (mask_we_i)     mask_q <= mask_d_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = raw_q & mask_q;
endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
  import rtc_pkg::*;
#(
  parameter int unsigned AW = RTC_AW,
  parameter int unsigned DW = RTC_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] lr_i,
  input  logic [DW-1:0] mr_i,
  input  logic          raw_i,
  input  logic          mask_i,
  output rtc_wr_t       wr_o,
  output logic [DW-1:0] rdata_o,
  output logic          err_o
);
  localparam int unsigned WIDX_W  = AW - 2;
  localparam int unsigned ID_BASE = (1 << AW) - 4 * ID_WORDS;

  logic [WIDX_W-1:0] widx;
  logic              aligned, in_id, rd_acc, wr_acc, legal_rd, legal_wr;
  logic [DW-1:0]     rd_val, rdata_q;
  logic              err_q;

  assign widx    = addr_i[AW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign in_id   = (widx >= WIDX_W'(ID_BASE >> 2));
  assign rd_acc  = sel_i && !wr_i;
  assign wr_acc  = sel_i && wr_i;

  always_comb begin
    rd_val   = '0;
    legal_rd = 1'b1;
    legal_wr = 1'b0;
    if (!aligned) begin
      legal_rd = 1'b0;
    end else if (in_id) begin
      rd_val = DW'(id_byte(widx[2:0]));
    end else begin
      case (widx)
        WIDX_W'(OFF_CNT >> 2):   rd_val = cnt_i;
        WIDX_W'(OFF_MATCH >> 2): begin rd_val = mr_i; legal_wr = 1'b1; end
        WIDX_W'(OFF_LOAD >> 2):  begin rd_val = lr_i; legal_wr = 1'b1; end
        WIDX_W'(OFF_CTRL >> 2):  begin rd_val = DW'(1); legal_wr = 1'b1; end
        WIDX_W'(OFF_MASK >> 2):  begin rd_val = DW'(mask_i); legal_wr = 1'b1; end
        WIDX_W'(OFF_RAW >> 2):   rd_val = DW'(raw_i);
        WIDX_W'(OFF_MIS >> 2):   rd_val = DW'(raw_i & mask_i);
        WIDX_W'(OFF_CLR >> 2):   begin legal_rd = 1'b0; legal_wr = 1'b1; end
        default:                 legal_rd = 1'b0;
      endcase
    end
  end

  always_comb begin
    wr_o          = '0;
    wr_o.match_we = wr_acc && legal_wr && (widx == WIDX_W'(OFF_MATCH >> 2));
    wr_o.load_we  = wr_acc && legal_wr && (widx == WIDX_W'(OFF_LOAD >> 2));
    wr_o.mask_we  = wr_acc && legal_wr && (widx == WIDX_W'(OFF_MASK >> 2));
    wr_o.clr_we   = wr_acc && legal_wr && (widx == WIDX_W'(OFF_CLR >> 2));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= (rd_acc && legal_rd) ? rd_val : '0;
      err_q   <= (rd_acc && !legal_rd) || (wr_acc && !legal_wr);
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned AW = RTC_AW,
  parameter int unsigned DW = RTC_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic          irq_o
);
  rtc_wr_t       wr_s;
  logic [DW-1:0] cnt, lr, mr;
  logic          hit, raw, mask;

  rtc_counter #(.DW(DW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_we_i  (wr_s.load_we),
    .match_we_i (wr_s.match_we),
    .wdata_i    (wdata_i),
    .cnt_o      (cnt),
    .lr_o       (lr),
    .mr_o       (mr),
    .hit_o      (hit)
  );

  rtc_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .clr_we_i  (wr_s.clr_we),
    .mask_we_i (wr_s.mask_we),
    .mask_d_i  (wdata_i[0]),
    .raw_o     (raw),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  rtc_regif #(.AW(AW), .DW(DW)) u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .cnt_i   (cnt),
    .lr_i    (lr),
    .mr_i    (mr),
    .raw_i   (raw),
    .mask_i  (mask),
    .wr_o    (wr_s),
    .rdata_o (rdata_o),
    .err_o   (err_o)
  );
endmodule

// File: rtl/rtc_sva.sv
module rtc_sva #(
  parameter int unsigned DW = rtc_pkg::RTC_DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          err_o,
  input logic          irq_o,
  input logic [DW-1:0] cnt,
  input logic          hit,
  input logic          raw,
  input logic          load_we,
  input logic          clr_we,
  input logic          mask_we
);
  assert_cnt_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_we) |=> cnt == $past(cnt) + DW'(1));

  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_we) |=> $stable(cnt));

  assert_load_val_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we |=> cnt == $past(wdata_i));

  assert_alarm_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> raw);

  assert_irq_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(hit) || $past(mask_we)));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we && !hit) |=> !raw);

  assert_err_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));
endmodule

bind sec_rtc rtc_sva #(.DW(DW)) u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .err_o   (err_o),
  .irq_o   (irq_o),
  .cnt     (cnt),
  .hit     (hit),
  .raw     (raw),
  .load_we (wr_s.load_we),
  .clr_we  (wr_s.clr_we),
  .mask_we (wr_s.mask_we)
);

// File: tb/sec_rtc_test.sv
module sec_rtc_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err, irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  logic [31:0] m_cnt = '0, m_mr = '0, m_lr = '0;
  logic        m_mask = 1'b0, m_raw = 1'b0;

  sec_rtc uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sel_i(sel), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    d = '0; e = 1'b0;
    if (a[1:0] != 2'b00) e = 1'b1;
    else if (a >= 12'hFE0) begin
      case (a[4:2])
        3'd0: d = 32'h31; 3'd1: d = 32'h10; 3'd2: d = 32'h14; 3'd3: d = 32'h00;
        3'd4: d = 32'h0D; 3'd5: d = 32'hF0; 3'd6: d = 32'h05; default: d = 32'hB1;
      endcase
    end else begin
      case (a)
        12'h000: d = m_cnt;
        12'h004: d = m_mr;
        12'h008: d = m_lr;
        12'h00C: d = 32'h1;
        12'h010: d = {31'b0, m_mask};
        12'h014: d = {31'b0, m_raw};
        12'h018: d = {31'b0, m_raw & m_mask};
        default: e = 1'b1;
      endcase
    end
  endtask

  function automatic bit writable(input logic [11:0] a);
    return a == 12'h004 || a == 12'h008 || a == 12'h00C || a == 12'h010 || a == 12'h01C;
  endfunction

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; d = rdata; e = err;
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] v, output logic e);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = v;
    @(negedge clk); sel = 1'b0; wr = 1'b0; e = err;
    if (a == 12'h004) m_mr = v;
    if (a == 12'h008) begin m_lr = v; m_cnt = v; end
    if (a == 12'h010) m_mask = v[0];
    if (a == 12'h01C) m_raw = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a);
    logic [31:0] d, ed;
    logic e, ee;
    bus_rd(a, d, e);
    model_rd(a, ed, ee);
    chk($sformatf("%s rd %h data", tag, a), d, ed);
    chk($sformatf("%s rd %h err", tag, a), {31'b0, e}, {31'b0, ee});
  endtask

  task automatic wr_ok(input string tag, input logic [11:0] a, input logic [31:0] v);
    logic e;
    bus_wr(a, v, e);
    chk($sformatf("%s wr %h err", tag, a), {31'b0, e}, 32'h0);
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    m_cnt = m_cnt + 1;
    if (m_cnt == m_mr) m_raw = 1'b1;
  endtask

  task automatic state_chk(input string tag);
    rd_chk(tag, 12'h000); rd_chk(tag, 12'h004); rd_chk(tag, 12'h008);
    rd_chk(tag, 12'h010); rd_chk(tag, 12'h014);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic e;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 err", {31'b0, err}, 32'h0);
    rst_n = 1'b1;
    state_chk("R1");
    rd_chk("R1 mis", 12'h018);

    // R10: no read gives zero read data
    @(negedge clk); @(negedge clk);
    chk("R10 idle rdata", rdata, 32'h0);

    // R7: control
    rd_chk("R7", 12'h00C);
    wr_ok("R7", 12'h00C, 32'h0);
    rd_chk("R7 after wr", 12'h00C);

    // R3 and R2: load then ticks
    wr_ok("R3", 12'h008, 32'h0000_1234);
    rd_chk("R3 cnt", 12'h000);
    rd_chk("R3 lr", 12'h008);
    for (int k = 0; k < 5; k++) begin
      do_tick();
      rd_chk("R2 tick", 12'h000);
    end
    repeat (4) @(negedge clk);
    rd_chk("R2 hold", 12'h000);

    // R3: load wins over same-cycle tick
    @(negedge clk); tick = 1'b1; sel = 1'b1; wr = 1'b1; addr = 12'h008; wdata = 32'hABCD_0000;
    @(negedge clk); tick = 1'b0; sel = 1'b0; wr = 1'b0;
    m_cnt = 32'hABCD_0000; m_lr = 32'hABCD_0000;
    rd_chk("R3 load vs tick", 12'h000);

    // R4 and R5: match with mask
    wr_ok("R4", 12'h008, 32'd10);
    wr_ok("R4", 12'h004, 32'd13);
    wr_ok("R5", 12'h010, 32'h1);
    for (int k = 0; k < 3; k++) begin
      do_tick();
      chk("R5 irq", {31'b0, irq}, {31'b0, m_raw & m_mask});
    end
    chk("R4 raw model", {31'b0, m_raw}, 32'h1);
    rd_chk("R4", 12'h014);
    rd_chk("R5 mis", 12'h018);
    wr_ok("R5", 12'h010, 32'hFFFF_FFFE);
    chk("R5 masked irq", {31'b0, irq}, 32'h0);
    rd_chk("R5 mis off", 12'h018);
    rd_chk("R5 raw kept", 12'h014);
    wr_ok("R5", 12'h010, 32'h1);
    chk("R5 irq back", {31'b0, irq}, 32'h1);

    // R6: clear with zero data
    wr_ok("R6", 12'h01C, 32'h0);
    chk("R6 irq", {31'b0, irq}, 32'h0);
    rd_chk("R6", 12'h014);

    // R4: match reached through wraparound
    wr_ok("R4 wrap", 12'h008, 32'hFFFF_FFFE);
    wr_ok("R4 wrap", 12'h004, 32'h1);
    for (int k = 0; k < 3; k++) begin
      do_tick();
      rd_chk("R4 wrap", 12'h014);
      rd_chk("R2 wrap", 12'h000);
    end
    chk("R4 wrap irq", {31'b0, irq}, 32'h1);
    wr_ok("R6", 12'h01C, 32'h5A5A_5A5A);

    // R6: set beats same-cycle clear
    wr_ok("R6", 12'h008, 32'd20);
    wr_ok("R6", 12'h004, 32'd21);
    @(negedge clk); tick = 1'b1; sel = 1'b1; wr = 1'b1; addr = 12'h01C; wdata = 32'h1;
    @(negedge clk); tick = 1'b0; sel = 1'b0; wr = 1'b0;
    m_cnt = 32'd21; m_raw = 1'b1;
    rd_chk("R6 set wins", 12'h014);
    chk("R6 set wins irq", {31'b0, irq}, 32'h1);

    // R8 and R9: every word offset read, plus misaligned reads
    for (int w = 0; w < 1024; w++) rd_chk("R8 R9 sweep", 12'(w * 4));
    for (int k = 1; k < 4; k++) rd_chk("R9 misaligned", 12'(k));

    // R9: illegal writes change nothing
    wr_ok("R9", 12'h008, 32'h0000_0777);
    for (int w = 0; w < 1024; w++) begin
      if (!writable(12'(w * 4))) begin
        bus_wr(12'(w * 4), 32'hFFFF_FFFF, e);
        chk($sformatf("R9 wr %h err", w * 4), {31'b0, e}, 32'h1);
      end
    end
    bus_wr(12'h00A, 32'hFFFF_FFFF, e);
    chk("R9 misaligned wr err", {31'b0, e}, 32'h1);
    state_chk("R9 after");
    chk("R9 irq", {31'b0, irq}, {31'b0, m_raw & m_mask});

    finish_run();
  end
endmodule